// File: doc/BRIEF.md
# Vector-Width Frequency License Controller

This block sits beside one core and decides which of three ordered frequency licenses that core runs under: level 0 (fastest), level 1, and level 2 (slowest). Every cycle it may accept one retired-instruction descriptor. The descriptor gives an operand-width code and a flag that marks work done on the floating-point/multiply unit as "heavy". From this stream the controller raises the license in one of two ways. A hard raise halts the core for a fixed number of stall cycles. A soft raise first asks the issue logic to throttle vector issue to a quarter of its rate. The license itself moves only when heavy work is dense enough inside a sliding time window. The controller lowers the license one step at a time, and only after a quiet period.

Descriptors enter on a valid/ready handshake. A descriptor counts only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` falls while the halt request is raised, and the controller has no buffer. The source must therefore hold a descriptor or drop it during a halt. A descriptor offered while ready is low has no effect. The outputs `lic_o`, `halt_o` and `throttle_o` are plain control levels that the clock, voltage and issue logic read. Window length, density threshold, quiet period and stall length are parameters.

Top module: `lic_ctrl`

## Requirements
- R1: After reset `lic_o` is 0 (codes: 0 = fastest level, 1 = middle, 2 = slowest; 3 never appears), `halt_o` and `throttle_o` are low, and `in_ready` is high.
- R2: Width code 0 is scalar, 1 is 128-bit, 2 is 256-bit and 3 is 512-bit, and `in_heavy` = 1 marks heavy. Scalar and 128-bit descriptors (heavy or light) and light 256-bit descriptors never raise the license and never set `throttle_o`.
- R3: A light 512-bit descriptor accepted at level 0 raises `halt_o` from the next cycle for exactly STALL cycles, with `lic_o` unchanged. `lic_o` becomes 1 on the cycle `halt_o` falls.
- R4: While `halt_o` is high, `in_ready` is low and offered descriptors have no effect on the license or the density windows.
- R5: Heavy 256-bit descriptors target level 1 and heavy 512-bit descriptors target level 2. When the THRESH-th accepted descriptor for a target above the current level lands within the last WIN cycles, `lic_o` moves to that target on the next cycle with no halt. This includes a move from level 0 straight to level 2.
- R6: Heavy descriptors that are sparse in time, or diluted among other descriptors so that fewer than THRESH fall in any WIN-cycle span, leave `lic_o` unchanged.
- R7: `throttle_o` is high from the cycle after a qualifying heavy descriptor is accepted for as long as that descriptor remains within the last WIN cycles.
- R8: A descriptor whose required level is at or below the current level causes no halt, no throttle and no change of `lic_o`.
- R9: When the license is above 0 and RELAX consecutive cycles pass without an accepted descriptor that requires the current level or higher, `lic_o` drops by exactly one level. Any such descriptor restarts the count.
- R10: On every license change the density windows and the quiet-period count restart, so `throttle_o` is low in the first cycle at the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered this cycle |
| in_ready | output | 1 | Controller accepts a descriptor this cycle (low during halt) |
| in_width | input | 2 | Operand width code |
| in_heavy | input | 1 | Descriptor uses the FP/multiply unit |
| lic_o | output | 2 | Current license level |
| halt_o | output | 1 | Core halt request, held through transition stalls |
| throttle_o | output | 1 | Limit vector issue to a quarter rate |

## Verification
The hardest situation to reach is one where ignoring input during a halt is visible at the ports. The stimulus drives dense heavy 512-bit descriptors through every stall cycle of a hard raise. These would reach the level-2 threshold within the stall if they were accepted. The license must therefore still land on level 1. The quiet-period restart is just as subtle. A single touching descriptor late in the countdown must push the drop a full RELAX cycles further out. The stimulus samples the level one cycle before and one cycle after the new expiry point.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    VW_SCALAR = 2'd0,
    VW_128    = 2'd1,
    VW_256    = 2'd2,
    VW_512    = 2'd3
  } vwidth_e;

  localparam logic [1:0] LIC_FAST = 2'd0;
  localparam logic [1:0] LIC_MID  = 2'd1;
  localparam logic [1:0] LIC_SLOW = 2'd2;
  localparam int unsigned NUM_TARGETS = 2;
endpackage

// File: rtl/lic_classify.sv
module lic_classify
  import lic_pkg::*;
(
  input  logic [1:0] width_i,
  input  logic       heavy_i,
  output logic [1:0] req_o,
  output logic       soft_o,
  output logic       hard_o
);
  always_comb begin
    req_o  = LIC_FAST;
    soft_o = 1'b0;
    hard_o = 1'b0;
    unique case (vwidth_e'(width_i))
      VW_256: begin
        if (heavy_i) begin
          req_o  = LIC_MID;
          soft_o = 1'b1;
        end
      end
      VW_512: begin
        if (heavy_i) begin
          req_o  = LIC_SLOW;
          soft_o = 1'b1;
        end else begin
          req_o  = LIC_MID;
          hard_o = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lic_density_win.sv
module lic_density_win #(
  parameter int unsigned WIN    = 16,
  parameter int unsigned THRESH = 4,
  localparam int unsigned CW    = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          hit_i,
  output logic [CW-1:0] cnt_o,
  output logic          reach_o
);
  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  cnt_q;
  logic [CW:0]    cnt_next;

  // hist_q[WIN-1] is the oldest entry and leaves the window on this edge
  assign cnt_next = {1'b0, cnt_q} + {{CW{1'b0}}, hit_i} - {{CW{1'b0}}, hist_q[WIN-1]};
  assign reach_o  = hit_i && (cnt_next >= (CW + 1)'(THRESH));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= {hist_q[WIN-2:0], hit_i};
      cnt_q  <= cnt_next[CW-1:0];
    end
  end
endmodule

// File: rtl/lic_relax_timer.sv
module lic_relax_timer #(
  parameter int unsigned RELAX = 64,
  localparam int unsigned RW   = $clog2(RELAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic active_i,
  input  logic touch_i,
  output logic expire_o
);
  logic [RW-1:0] cnt_q;

  assign expire_o = active_i && !touch_i && (cnt_q == RW'(RELAX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i || touch_i || !active_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + RW'(1);
    end
  end
endmodule

// File: rtl/lic_ctrl.sv
module lic_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned WIN    = 16,
  parameter int unsigned THRESH = 4,
  parameter int unsigned RELAX  = 64,
  parameter int unsigned STALL  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_width,
  input  logic       in_heavy,
  output logic [1:0] lic_o,
  output logic       halt_o,
  output logic       throttle_o
);
  localparam int unsigned CW  = $clog2(WIN + 1);
  localparam int unsigned HCW = (STALL > 1) ? $clog2(STALL) : 1;

  logic [1:0]     lic_q;
  logic           halt_q;
  logic [HCW-1:0] hcnt_q;

  logic           acc;
  logic [1:0]     cls_req;
  logic           cls_soft;
  logic           cls_hard;
  logic [NUM_TARGETS:1] hit;
  logic [NUM_TARGETS:1] reach;
  logic [CW-1:0]  cnt [1:NUM_TARGETS];
  logic           relax_exp;
  logic           halt_done;
  logic           chg;
  logic           touch;

  assign in_ready = !halt_q;
  assign acc      = in_valid && in_ready;

  lic_classify u_cls (
    .width_i (in_width),
    .heavy_i (in_heavy),
    .req_o   (cls_req),
    .soft_o  (cls_soft),
    .hard_o  (cls_hard)
  );

  for (genvar g = 1; g <= NUM_TARGETS; g++) begin : g_win
    assign hit[g] = acc && cls_soft && (cls_req == 2'(g)) && (lic_q < 2'(g));
    lic_density_win #(.WIN(WIN), .THRESH(THRESH)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (chg),
      .hit_i   (hit[g]),
      .cnt_o   (cnt[g]),
      .reach_o (reach[g])
    );
  end

  assign touch     = acc && (cls_req >= lic_q);
  assign halt_done = halt_q && (hcnt_q == '0);

  lic_relax_timer #(.RELAX(RELAX)) u_relax (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (chg),
    .active_i ((lic_q != LIC_FAST) && !halt_q),
    .touch_i  (touch),
    .expire_o (relax_exp)
  );

  assign chg = halt_done || (|reach) || (!halt_q && relax_exp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lic_q  <= LIC_FAST;
      halt_q <= 1'b0;
      hcnt_q <= '0;
    end else if (halt_q) begin
      if (halt_done) begin
        halt_q <= 1'b0;
        lic_q  <= LIC_MID;
      end else begin
        hcnt_q <= hcnt_q - HCW'(1);
      end
    end else if (reach[2]) begin
      lic_q <= LIC_SLOW;
    end else if (reach[1]) begin
      lic_q <= LIC_MID;
    end else if (acc && cls_hard && (lic_q == LIC_FAST)) begin
      halt_q <= 1'b1;
      hcnt_q <= HCW'(STALL - 1);
    end else if (relax_exp) begin
      lic_q <= lic_q - 2'd1;
    end
  end

  assign lic_o      = lic_q;
  assign halt_o     = halt_q;
  assign throttle_o = (cnt[1] != '0) || (cnt[2] != '0);
endmodule

// File: rtl/lic_ctrl_chk.sv
module lic_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_width,
  input logic       in_heavy,
  input logic [1:0] lic_o,
  input logic       halt_o,
  input logic       throttle_o
);
  // R1: only three levels exist
  a_r1_legal_level: assert property (@(posedge clk) disable iff (!rst_n)
    lic_o != 2'd3);

  // R3: light 512-bit at fastest level starts a halt
  a_r3_hard_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_width == 2'd3 && !in_heavy && lic_o == 2'd0) |=> halt_o);

  // R3: a halt always ends at the middle level
  a_r3_halt_lands_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_o) |-> (lic_o == 2'd1));

  // R4: level frozen while halted
  a_r4_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && $past(halt_o)) |-> $stable(lic_o));

  // R9: relaxation steps down exactly one level
  a_r9_one_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (lic_o < $past(lic_o)) |-> (lic_o == 2'($past(lic_o) - 2'd1)));

  // R10: windows cleared on any level change
  a_r10_throttle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lic_o != $past(lic_o)) |-> !throttle_o);
endmodule

bind lic_ctrl lic_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_width   (in_width),
  .in_heavy   (in_heavy),
  .lic_o      (lic_o),
  .halt_o     (halt_o),
  .throttle_o (throttle_o)
);

// File: tb/lic_ctrl_tb_top.sv
module lic_ctrl_tb_top;
  localparam int unsigned WIN    = 8;
  localparam int unsigned THRESH = 3;
  localparam int unsigned RELAX  = 20;
  localparam int unsigned STALL  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_width = 2'd0;
  logic       in_heavy = 1'b0;
  logic [1:0] lic_o;
  logic       halt_o;
  logic       throttle_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] lic;
    logic       halt;
    logic       thr;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  lic_ctrl #(.WIN(WIN), .THRESH(THRESH), .RELAX(RELAX), .STALL(STALL)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_width   (in_width),
    .in_heavy   (in_heavy),
    .lic_o      (lic_o),
    .halt_o     (halt_o),
    .throttle_o (throttle_o)
  );

  // Monitor: compares outputs shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (lic_o !== e.lic || halt_o !== e.halt || throttle_o !== e.thr || in_ready !== e.rdy) begin
        errors++;
        $display("FAIL %s: actual lic=%0d halt=%0b thr=%0b rdy=%0b expected lic=%0d halt=%0b thr=%0b rdy=%0b",
                 e.tag, lic_o, halt_o, throttle_o, in_ready, e.lic, e.halt, e.thr, e.rdy);
      end
    end
  end

  task automatic expect_st(input logic [1:0] l, input logic h, input logic t, input logic r,
                           input string tag);
    exp_t e;
    e.lic = l; e.halt = h; e.thr = t; e.rdy = r; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic cyc(input logic v, input logic [1:0] w, input logic hv);
    in_valid = v;
    in_width = w;
    in_heavy = hv;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_st(2'd0, 1'b0, 1'b0, 1'b1, "R1 reset state");
    idle(1);

    // R2: scalar, 128-bit heavy/light, 256-bit light
    for (int i = 0; i < 10; i++) cyc(1'b1, 2'd1, 1'b1);
    expect_st(2'd0, 1'b0, 1'b0, 1'b1, "R2 128-bit heavy");
    for (int i = 0; i < 5; i++) cyc(1'b1, 2'd0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 2'd2, 1'b0);
    expect_st(2'd0, 1'b0, 1'b0, 1'b1, "R2 256-bit light and scalar");

    // R6 / R7: sparse heavy 256-bit
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 2'd2, 1'b1);
      expect_st(2'd0, 1'b0, 1'b1, 1'b1, "R7 throttle after heavy");
      idle(WIN);
      expect_st(2'd0, 1'b0, 1'b0, 1'b1, "R6 sparse heavy no change");
    end

    // R6: diluted heavy, one in four
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 2'd2, 1'b1);
      cyc(1'b1, 2'd0, 1'b0);
      cyc(1'b1, 2'd1, 1'b0);
      cyc(1'b1, 2'd0, 1'b1);
    end
    expect_st(2'd0, 1'b0, 1'b1, 1'b1, "R6 diluted heavy no change");
    idle(WIN);

    // R5: dense heavy 256-bit, soft raise to middle
    cyc(1'b1, 2'd2, 1'b1);
    cyc(1'b1, 2'd2, 1'b1);
    expect_st(2'd0, 1'b0, 1'b1, 1'b1, "R5 below threshold");
    cyc(1'b1, 2'd2, 1'b1);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R5 soft raise to 1, R10 window cleared");

    // R9: touch restarts quiet period
    idle(15);
    cyc(1'b1, 2'd2, 1'b1);
    idle(RELAX - 1);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R9 touch restarts quiet count");
    idle(1);
    expect_st(2'd0, 1'b0, 1'b0, 1'b1, "R9 relax to 0");

    // R3 / R4: hard raise with dense heavy 512 offered during halt
    cyc(1'b1, 2'd3, 1'b0);
    expect_st(2'd0, 1'b1, 1'b0, 1'b0, "R3 halt starts");
    for (int i = 0; i < STALL - 1; i++) cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd0, 1'b1, 1'b0, 1'b0, "R4 halt held, input ignored");
    cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R3 lands on 1, R4 no raise to 2");

    // R8: at or below current level
    cyc(1'b1, 2'd3, 1'b0);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R8 light 512 at level 1");
    cyc(1'b1, 2'd2, 1'b1);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R8 heavy 256 at level 1");

    // R5: soft raise 1 -> 2
    cyc(1'b1, 2'd3, 1'b1);
    cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd1, 1'b0, 1'b1, 1'b1, "R5 heavy 512 below threshold");
    cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd2, 1'b0, 1'b0, 1'b1, "R5 soft raise to 2");
    for (int i = 0; i < 3; i++) cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd2, 1'b0, 1'b0, 1'b1, "R8 heavy 512 at level 2");

    // R9: step down one level at a time
    idle(RELAX - 1);
    expect_st(2'd2, 1'b0, 1'b0, 1'b1, "R9 still 2 before quiet end");
    idle(1);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R9 drop exactly one level");
    idle(RELAX - 1);
    expect_st(2'd1, 1'b0, 1'b0, 1'b1, "R9 count restarted at new level");
    idle(1);
    expect_st(2'd0, 1'b0, 1'b0, 1'b1, "R9 second drop");

    // R5: straight from 0 to 2 with no halt
    cyc(1'b1, 2'd3, 1'b1);
    cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd0, 1'b0, 1'b1, 1'b1, "R5 heavy 512 at 0 throttles");
    cyc(1'b1, 2'd3, 1'b1);
    expect_st(2'd2, 1'b0, 1'b0, 1'b1, "R5 direct raise 0 to 2 without halt");

    idle(3);
    done = 1'b1;
    finish_run();
  end
endmodule